// File: doc/BRIEF.md
# Adaptive-Precision Multiply Element with Column Combiner

This block is one processing element of a weight-stationary multiply array, together with the shift-and-add stage that sits at the foot of its column. The element holds sixteen 2-bit multipliers arranged as four groups. Each group multiplies the full signed 8-bit activation by one 2-bit digit of an 8-bit weight word. Each group feeds one partial-sum lane. The lane adds the group's product to the partial sum arriving from the element above and registers the total for the element below.

The way the weight word is read depends on a precision mode. It can hold a single signed 8-bit weight, two signed 4-bit weights taken from two interleaved weight tiles, or four signed 2-bit weights taken from four tiles. In each case the same multipliers do the work, so the lower precisions give two or four products per cycle. The combiner does not need per-element shifters. It weights the four lanes according to the mode and folds them into up to four running result accumulators.

The mode is latched only on a synchronous clear. This keeps the lanes and the accumulators from ever mixing two interpretations of the weight word.

Top module: `apx_pe_column`

## Requirements
- R1: After reset, every partial-sum lane and every result reads zero and the latched mode is full-width (encoding 2'b00).
- R2: One cycle after a cycle with valid_i high and clear_i low, lane g (bits [16g+15:16g] of psum_o) equals lane g of psum_i plus act_i times weight digit g (wgt_i[2g+1:2g]). That digit is taken as signed in four cases: in mode 2'b10 for every digit; in mode 2'b01 for digits 1 and 3; in modes 2'b00 and 2'b11 for digit 3. Otherwise it is taken as unsigned.
- R3: In mode 2'b00, result 0 accumulates act_i times the signed 8-bit weight, including the extreme operands -128 × -128. Results 1 to 3 stay zero.
- R4: In mode 2'b01, result 0 accumulates act_i times signed wgt_i[3:0] and result 1 accumulates act_i times signed wgt_i[7:4]. Results 2 and 3 stay zero.
- R5: In mode 2'b10, result g accumulates act_i times signed wgt_i[2g+1:2g] for g = 0..3.
- R6: Mode encoding 2'b11 behaves exactly as mode 2'b00.
- R7: A lane value reaches the results one cycle after it appears on psum_o. An input is therefore reflected in res_o (result g at bits [24g+23:24g]) two cycles after it is applied.
- R8: A cycle with valid_i low leaves the lanes unchanged and adds nothing to the results.
- R9: clear_i zeroes all lanes and results on the next edge and takes priority over valid_i. A lane value waiting to be combined is discarded.
- R10: mode_i is sampled only in a clear cycle. Changes to mode_i in any other cycle have no effect on how lanes or results are computed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of lanes and results; latches mode_i |
| mode_i | input | 2 | Precision mode: 00 one 8b weight, 01 two 4b weights, 10 four 2b weights, 11 as 00 |
| valid_i | input | 1 | Activation, weight and incoming lanes are valid this cycle |
| act_i | input | ACT_W | Signed activation |
| wgt_i | input | 8 | Packed weight word |
| psum_i | input | 4*LANE_W | Four partial-sum lanes from the element above |
| psum_o | output | 4*LANE_W | Four registered partial-sum lanes toward the element below |
| res_o | output | 4*ACC_W | Four combined, accumulated results |

## Verification
The bench aims at the digit sign rules, which are where a precision-adaptive multiplier usually breaks. It uses weights whose top bit is set in each sub-field, together with activation -128. A design that treats an inner digit as signed, or a field's top digit as unsigned, gives results that are off by a multiple of 4, 16 or 64 times the activation. The bench also changes mode_i outside clear cycles and raises clear_i while valid_i is high. A design that applies a mode change at once, or lets a pending lane leak past a clear, then shows results that fail to match on the next compare. Gaps in valid_i show up a design that keeps accumulating a stale lane, and these results are compared on every cycle.

// File: rtl/apx_pkg.sv
package apx_pkg;

   typedef enum logic [1:0] {
      APX_M8X8 = 2'b00,
      APX_M8X4 = 2'b01,
      APX_M8X2 = 2'b10,
      APX_MRSV = 2'b11
   } apx_mode_e;

   localparam int unsigned APX_GROUPS = 4;
   localparam int unsigned APX_DIG_W  = 2;
   localparam int unsigned APX_WGT_W  = APX_GROUPS * APX_DIG_W;

   // A weight digit carries negative weight only if it is the top digit of its field.
   function automatic logic digit_is_signed(apx_mode_e m, int unsigned g);
      case (m)
         APX_M8X2: return 1'b1;
         APX_M8X4: return (g % 2) == 1;
         default:  return g == (APX_GROUPS - 1);
      endcase
   endfunction

endpackage

// File: rtl/apx_digit_grp.sv
module apx_digit_grp #(
   parameter int ACT_W  = 8,
   parameter int PROD_W = ACT_W + 4
) (
   input  logic [ACT_W-1:0]         act_i,
   input  logic [1:0]               wdig_i,
   input  logic                     wsgn_i,
   output logic signed [PROD_W-1:0] prod_o
);
   localparam int NDIG = ACT_W / 2;

   if ((ACT_W % 2) != 0 || ACT_W < 4) begin : g_bad_act
      $error("apx_digit_grp: ACT_W must be even and at least 4");
   end
   if (PROD_W < ACT_W + 3) begin : g_bad_prod
      $error("apx_digit_grp: PROD_W too narrow");
   end

   logic signed [PROD_W-1:0] term [NDIG];
   logic                     w_top;

   assign w_top = wsgn_i & wdig_i[1];

   for (genvar i = 0; i < NDIG; i++) begin : g_dig
      logic               a_top;
      logic signed [5:0]  a_ext;
      logic signed [5:0]  w_ext;
      logic signed [5:0]  pp;
      if (i == NDIG - 1) begin : g_msd
         assign a_top = act_i[2*i+1];
      end else begin : g_lsd
         assign a_top = 1'b0;
      end
      assign a_ext   = {{4{a_top}}, act_i[2*i +: 2]};
      assign w_ext   = {{4{w_top}}, wdig_i};
      assign pp      = a_ext * w_ext;
      assign term[i] = {{(PROD_W-6){pp[5]}}, pp} <<< (2*i);
   end

   always_comb begin
      prod_o = '0;
      for (int i = 0; i < NDIG; i++) prod_o = prod_o + term[i];
   end

endmodule

// File: rtl/apx_pe.sv
module apx_pe
   import apx_pkg::*;
#(
   parameter int ACT_W  = 8,
   parameter int LANE_W = 16
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        clear_i,
   input  logic                        valid_i,
   input  apx_mode_e                   mode_i,
   input  logic [ACT_W-1:0]            act_i,
   input  logic [APX_WGT_W-1:0]        wgt_i,
   input  logic [APX_GROUPS*LANE_W-1:0] psum_i,
   output logic [APX_GROUPS*LANE_W-1:0] psum_o,
   output logic                        vld_o
);
   localparam int PROD_W = ACT_W + 4;

   if (LANE_W <= PROD_W) begin : g_bad_lane
      $error("apx_pe: LANE_W must exceed the product width");
   end

   for (genvar g = 0; g < APX_GROUPS; g++) begin : g_grp
      logic signed [PROD_W-1:0] prod;
      logic        [LANE_W-1:0] lane_q;
      logic        [LANE_W-1:0] lane_d;

      apx_digit_grp #(.ACT_W(ACT_W), .PROD_W(PROD_W)) u_grp (
         .act_i  (act_i),
         .wdig_i (wgt_i[APX_DIG_W*g +: APX_DIG_W]),
         .wsgn_i (digit_is_signed(mode_i, g)),
         .prod_o (prod)
      );

      assign lane_d = psum_i[g*LANE_W +: LANE_W]
                    + {{(LANE_W-PROD_W){prod[PROD_W-1]}}, prod};

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      lane_q <= '0;
         else if (clear_i) lane_q <= '0;
         else if (valid_i) lane_q <= lane_d;
      end

      assign psum_o[g*LANE_W +: LANE_W] = lane_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_o <= 1'b0;
      else         vld_o <= valid_i & ~clear_i;
   end

endmodule

// File: rtl/apx_col_combiner.sv
module apx_col_combiner
   import apx_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int ACC_W  = 24
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         clear_i,
   input  logic                         vld_i,
   input  apx_mode_e                    mode_i,
   input  logic [APX_GROUPS*LANE_W-1:0] lane_i,
   output logic [APX_GROUPS*ACC_W-1:0]  res_o
);
   if (ACC_W < LANE_W + 6) begin : g_bad_acc
      $error("apx_col_combiner: ACC_W must cover the widest shifted lane sum");
   end

   logic signed [ACC_W-1:0] ext  [APX_GROUPS];
   logic signed [ACC_W-1:0] comb [APX_GROUPS];

   for (genvar g = 0; g < APX_GROUPS; g++) begin : g_ext
      assign ext[g] = {{(ACC_W-LANE_W){lane_i[g*LANE_W+LANE_W-1]}},
                       lane_i[g*LANE_W +: LANE_W]};
   end

   always_comb begin
      for (int g = 0; g < APX_GROUPS; g++) comb[g] = '0;
      case (mode_i)
         APX_M8X2: begin
            for (int g = 0; g < APX_GROUPS; g++) comb[g] = ext[g];
         end
         APX_M8X4: begin
            comb[0] = ext[0] + (ext[1] <<< 2);
            comb[1] = ext[2] + (ext[3] <<< 2);
         end
         default: begin
            comb[0] = ext[0] + (ext[1] <<< 2) + (ext[2] <<< 4) + (ext[3] <<< 6);
         end
      endcase
   end

   for (genvar g = 0; g < APX_GROUPS; g++) begin : g_acc
      logic signed [ACC_W-1:0] acc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      acc_q <= '0;
         else if (clear_i) acc_q <= '0;
         else if (vld_i)   acc_q <= acc_q + comb[g];
      end
      assign res_o[g*ACC_W +: ACC_W] = acc_q;
   end

endmodule

// File: rtl/apx_pe_column.sv
module apx_pe_column
   import apx_pkg::*;
#(
   parameter int ACT_W  = 8,
   parameter int LANE_W = 16,
   parameter int ACC_W  = 24
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         clear_i,
   input  logic [1:0]                   mode_i,
   input  logic                         valid_i,
   input  logic [ACT_W-1:0]             act_i,
   input  logic [APX_WGT_W-1:0]         wgt_i,
   input  logic [APX_GROUPS*LANE_W-1:0] psum_i,
   output logic [APX_GROUPS*LANE_W-1:0] psum_o,
   output logic [APX_GROUPS*ACC_W-1:0]  res_o
);
   apx_mode_e mode_q;
   logic      lane_vld;

   // Mode only moves while everything downstream is being cleared.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mode_q <= APX_M8X8;
      else if (clear_i) mode_q <= apx_mode_e'(mode_i);
   end

   apx_pe #(.ACT_W(ACT_W), .LANE_W(LANE_W)) u_pe (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .valid_i (valid_i),
      .mode_i  (mode_q),
      .act_i   (act_i),
      .wgt_i   (wgt_i),
      .psum_i  (psum_i),
      .psum_o  (psum_o),
      .vld_o   (lane_vld)
   );

   apx_col_combiner #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_comb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .vld_i   (lane_vld),
      .mode_i  (mode_q),
      .lane_i  (psum_o),
      .res_o   (res_o)
   );

endmodule

// File: rtl/apx_pe_column_chk.sv
module apx_pe_column_chk
   import apx_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int ACC_W  = 24
) (
   input logic                         clk_i,
   input logic                         rst_ni,
   input logic                         clear_i,
   input logic                         valid_i,
   input logic [1:0]                   mode_q,
   input logic [APX_GROUPS*LANE_W-1:0] psum_o,
   input logic [APX_GROUPS*ACC_W-1:0]  res_o
);
   // R9: a clear empties lanes and results on the next edge
   p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(clear_i) |-> (psum_o == '0) && (res_o == '0));

   // R10: the latched mode moves only after a clear cycle
   p_mode_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(clear_i) |-> $stable(mode_q));

   // R8: an idle cycle leaves the lanes untouched
   p_lane_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!valid_i) && $past(!clear_i)) |-> $stable(psum_o));

   // R7 and R8: nothing is added when no lane was produced the cycle before
   p_no_accum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(valid_i, 2) && !$past(clear_i)) |-> $stable(res_o));

   // R3 and R6: full-width modes touch only result 0
   p_wide_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == 2'b00 || mode_q == 2'b11) |-> (res_o[APX_GROUPS*ACC_W-1:ACC_W] == '0));

   // R4: half-width mode touches only results 0 and 1
   p_half_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == 2'b01) |-> (res_o[APX_GROUPS*ACC_W-1:2*ACC_W] == '0));

endmodule

bind apx_pe_column apx_pe_column_chk #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .clear_i (clear_i),
   .valid_i (valid_i),
   .mode_q  (mode_q),
   .psum_o  (psum_o),
   .res_o   (res_o)
);

// File: tb/apx_pe_column_tb.sv
`timescale 1ns/1ps
module apx_pe_column_tb;
   localparam int LW = 16;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          valid = 1'b0;
   logic [7:0]    act = '0;
   logic [7:0]    wgt = '0;
   logic [4*LW-1:0] pin = '0;
   logic [4*LW-1:0] pout;
   logic [4*AW-1:0] res;

   int n_cmp = 0;
   int n_bad = 0;
   string cur = "R1";

   logic signed [LW-1:0] m_lane [4];
   logic signed [AW-1:0] m_acc  [4];
   bit                   m_lv;
   int                   m_mode;

   always #2.5 clk = ~clk;

   apx_pe_column u_dut (
      .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .mode_i(mode),
      .valid_i(valid), .act_i(act), .wgt_i(wgt), .psum_i(pin),
      .psum_o(pout), .res_o(res)
   );

   function automatic int wdigit(int w, int g, int md);
      int d = (w >> (2*g)) & 3;
      bit s;
      if (md == 2)      s = 1;
      else if (md == 1) s = (g == 1) || (g == 3);
      else              s = (g == 3);
      if (s && d > 1) d = d - 4;
      return d;
   endfunction

   task automatic model_edge();
      int a, c [4];
      a = int'($signed(act));
      if (clear) begin
         foreach (m_lane[g]) begin m_lane[g] = '0; m_acc[g] = '0; end
         m_lv = 0;
         m_mode = int'(mode);
         return;
      end
      if (m_lv) begin
         foreach (c[g]) c[g] = 0;
         if (m_mode == 1) begin
            c[0] = int'(m_lane[0]) + 4*int'(m_lane[1]);
            c[1] = int'(m_lane[2]) + 4*int'(m_lane[3]);
         end else if (m_mode == 2) begin
            foreach (c[g]) c[g] = int'(m_lane[g]);
         end else begin
            c[0] = int'(m_lane[0]) + 4*int'(m_lane[1]) + 16*int'(m_lane[2]) + 64*int'(m_lane[3]);
         end
         foreach (m_acc[g]) m_acc[g] = AW'(int'(m_acc[g]) + c[g]);
      end
      if (valid)
         foreach (m_lane[g])
            m_lane[g] = LW'(int'($signed(pin[g*LW +: LW])) + a * wdigit(int'(wgt), g, m_mode));
      m_lv = valid;
   endtask

   task automatic compare();
      for (int g = 0; g < 4; g++) begin
         n_cmp++;
         if (pout[g*LW +: LW] !== m_lane[g]) begin
            n_bad++;
            $display("FAIL %s lane%0d got %0d exp %0d", cur, g,
                     $signed(pout[g*LW +: LW]), m_lane[g]);
         end
         n_cmp++;
         if (res[g*AW +: AW] !== m_acc[g]) begin
            n_bad++;
            $display("FAIL %s res%0d got %0d exp %0d", cur, g,
                     $signed(res[g*AW +: AW]), m_acc[g]);
         end
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic drive(bit v, logic [7:0] a, logic [7:0] w, bit rnd_psum);
      valid = v; act = a; wgt = w; clear = 1'b0;
      for (int g = 0; g < 4; g++)
         pin[g*LW +: LW] = rnd_psum ? LW'(int'($urandom_range(4000)) - 2000) : '0;
      tick();
   endtask

   task automatic do_clear(logic [1:0] md);
      clear = 1'b1; mode = md; valid = 1'b0;
      tick();
      clear = 1'b0;
   endtask

   task automatic burst(int n, int vpct, bit rnd_psum);
      for (int i = 0; i < n; i++)
         drive(($urandom_range(99) < vpct), 8'($urandom), 8'($urandom), rnd_psum);
   endtask

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL watchdog expired in %s", cur);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      foreach (m_lane[g]) begin m_lane[g] = '0; m_acc[g] = '0; end
      m_lv = 0; m_mode = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur = "R1"; compare();                      // R1 reset state
      tick();

      cur = "R3"; do_clear(2'b00);                // R3 full width, extreme operands
      drive(1, 8'h80, 8'h80, 0);
      drive(1, 8'h7f, 8'h80, 0);
      drive(1, 8'h80, 8'h7f, 0);
      burst(20, 100, 0);

      cur = "R7"; drive(1, 8'h05, 8'h03, 0);      // R7 single input then idle
      drive(0, 8'h00, 8'h00, 0);
      drive(0, 8'h00, 8'h00, 0);

      cur = "R4"; do_clear(2'b01);                // R4 two 4b weights
      drive(1, 8'h80, 8'h88, 0);
      drive(1, 8'h80, 8'h77, 0);
      burst(20, 100, 0);

      cur = "R5"; do_clear(2'b10);                // R5 four 2b weights
      drive(1, 8'h80, 8'haa, 0);
      drive(1, 8'h7f, 8'h55, 0);
      burst(20, 100, 0);

      cur = "R6"; do_clear(2'b11);                // R6 reserved mode as full width
      drive(1, 8'h80, 8'h80, 0);
      burst(15, 100, 0);

      cur = "R2"; do_clear(2'b01);                // R2 lanes add the incoming psum
      burst(25, 100, 1);
      do_clear(2'b10);
      burst(25, 100, 1);

      cur = "R8"; do_clear(2'b00);                // R8 gaps in valid
      burst(40, 50, 1);

      cur = "R10"; do_clear(2'b10);               // R10 mode_i wiggles outside clear
      for (int i = 0; i < 20; i++) begin
         mode = 2'($urandom);
         drive(1, 8'($urandom), 8'($urandom), 0);
      end

      cur = "R9";                                  // R9 clear wins over valid
      drive(1, 8'h80, 8'hff, 1);
      clear = 1'b1; mode = 2'b01; valid = 1'b1; act = 8'h40; wgt = 8'h33;
      tick();
      clear = 1'b0;
      drive(1, 8'h80, 8'h88, 0);
      drive(0, 8'h00, 8'h00, 0);
      drive(0, 8'h00, 8'h00, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule